// File: doc/BRIEF.md
# Snooping MSI Cache Controller

This block is the per-processor controller for a small direct-mapped, write-back cache that keeps coherence with its peers on a shared broadcast bus by invalidation. Each line holds a one-word block and is tracked as Invalid, Shared (clean, readable) or Exclusive (the sole copy, writable and dirty). The processor side presents read and write requests. Hits complete locally. Misses obtain bus ownership through a request/grant pair, optionally write back a dirty victim, then issue a read-miss or write-miss and wait for the memory's fill.

On the snoop side the controller watches transactions issued by other caches. A foreign read-miss to a line held Exclusive makes it report its dirty data and keep the line as Shared. A foreign write-miss removes the local copy, and reports the data first if the line was dirty. The bus is atomic: one owner at a time, and no snoop arrives while this cache owns it.

The request port follows valid/ready rules. A request is taken on a clock edge where `cpu_req_valid` and `cpu_req_ready` are both high, and the requester holds its fields steady until then. The response is a single-cycle `cpu_rsp_valid` pulse that cannot be stalled. The requester must be ready to take it.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high and `bus_req`, `bus_out_valid`, `snp_dirty` and `cpu_rsp_valid` are low.
- R2: A read to a line held Shared or Exclusive with a matching tag returns the line's data with `cpu_rsp_valid` one cycle after acceptance, and raises no `bus_req`.
- R3: A write to a line held Exclusive with a matching tag stores the data and responds one cycle after acceptance, with no bus activity.
- R4: A read miss issues a command of code 1 (read-miss) carrying the block address. The fill data is returned to the CPU and the line becomes Shared.
- R5: A write to a line that is Invalid, Shared or holds another tag issues code 2 (write-miss). The line then becomes Exclusive holding the write data, and the response echoes that data.
- R6: When the line to be replaced is Exclusive with a different tag, a write-back of code 3 carrying the victim's address and data is issued in the cycle just before the miss command.
- R7: Nothing is placed on the bus and the line is not changed before `bus_gnt`. `cpu_req_ready` stays low from acceptance of a miss until its response. The victim is judged at grant time, so a victim that a snoop invalidated while the request waited is not written back.
- R8: A snooped read-miss (code 1) to a line held Exclusive raises `snp_dirty` with `snp_data` equal to the line's data one cycle later. The line becomes Shared, so later reads hit and later writes miss.
- R9: A snooped write-miss (code 2) to a matching line moves it to Invalid. If the line was Exclusive, it also reports dirty data as in R8.
- R10: A snoop whose tag differs, whose line is Invalid, or whose code is 3 leaves the line unchanged and keeps `snp_dirty` low.
- R11: In any cycle with `snp_valid` high, `cpu_req_ready` is low, so the snoop takes priority over a CPU request in that cycle.
- R12: `bus_req` is high from the cycle after a miss is accepted until the fill arrives, and is low in the cycle after the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Controller can take a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Block address (low IDX_W bits select the line) |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read data, or the written data for writes |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_out_valid | output | 1 | Command on the bus this cycle |
| bus_out_cmd | output | 2 | 1 read-miss, 2 write-miss, 3 write-back |
| bus_out_addr | output | ADDR_W | Command block address |
| bus_out_data | output | DATA_W | Write-back data |
| fill_valid | input | 1 | Memory reply to this cache's miss |
| fill_data | input | DATA_W | Reply data |
| snp_valid | input | 1 | Foreign bus command present |
| snp_cmd | input | 2 | Foreign command code |
| snp_addr | input | ADDR_W | Foreign block address |
| snp_dirty | output | 1 | Dirty copy found (one cycle after the snoop) |
| snp_data | output | DATA_W | Dirty data supplied |

## Verification
Two functions can fall in the same cycle: a snoop and a CPU request. One case is a snoop that arrives together with a request. The bench presents both together and checks that `cpu_req_ready` is low, that no response follows, and that the snoop's dirty reply appears. The other case is a snoop that invalidates a dirty victim while a miss is waiting for grant. The bench holds back the grant, injects the snoop, and judges the later bus traffic: no write-back may appear, only the miss command.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    C_IDLE = 3'd0,
    C_ARB  = 3'd1,
    C_WB   = 3'd2,
    C_CMD  = 3'd3,
    C_WAIT = 3'd4
  } ctl_st_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  line_st_e          st_val,
  input  logic              ln_we,
  input  logic [IDX_W-1:0]  ln_idx,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  input  line_st_e          ln_state
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
    end else begin
      if (ln_we) st_q[ln_idx] <= ln_state;
      if (st_we) st_q[st_idx] <= st_val;
    end
  end

  always_ff @(posedge clk) begin
    if (ln_we) begin
      tag_q[ln_idx]  <= ln_tag;
      data_q[ln_idx] <= ln_data;
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = data_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = data_q[b_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [ADDR_W-1:0]       snp_addr,
  output logic [IDX_W-1:0]        b_idx,
  input  line_st_e                b_state,
  input  logic [ADDR_W-IDX_W-1:0] b_tag,
  input  logic [DATA_W-1:0]       b_data,
  output logic                    st_we,
  output logic [IDX_W-1:0]        st_idx,
  output line_st_e                st_val,
  output logic                    snp_dirty,
  output logic [DATA_W-1:0]       snp_data
);
  logic match, is_rd, is_wr, dirty_now;

  assign b_idx  = snp_addr[IDX_W-1:0];
  assign st_idx = snp_addr[IDX_W-1:0];
  assign match  = snp_valid && (b_state != LN_INV) && (b_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign is_rd  = (snp_cmd == BC_RDMISS);
  assign is_wr  = (snp_cmd == BC_WRMISS);
  assign dirty_now = match && (b_state == LN_EXC) && (is_rd || is_wr);

  always_comb begin
    st_we  = 1'b0;
    st_val = b_state;
    if (match && is_wr) begin
      st_we  = 1'b1;
      st_val = LN_INV;
    end else if (match && is_rd && b_state == LN_EXC) begin
      st_we  = 1'b1;
      st_val = LN_SHR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_dirty <= 1'b0;
      snp_data  <= '0;
    end else begin
      snp_dirty <= dirty_now;
      snp_data  <= dirty_now ? b_data : '0;
    end
  end
endmodule

// File: rtl/msi_cpu_ctrl.sv
module msi_cpu_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req_valid,
  output logic                    cpu_req_ready,
  input  logic                    cpu_req_we,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  input  logic [DATA_W-1:0]       cpu_req_wdata,
  output logic                    cpu_rsp_valid,
  output logic [DATA_W-1:0]       cpu_rsp_rdata,
  input  logic                    snp_valid,
  output logic [IDX_W-1:0]        a_idx,
  input  line_st_e                a_state,
  input  logic [ADDR_W-IDX_W-1:0] a_tag,
  input  logic [DATA_W-1:0]       a_data,
  output logic                    ln_we,
  output logic [IDX_W-1:0]        ln_idx,
  output logic [ADDR_W-IDX_W-1:0] ln_tag,
  output logic [DATA_W-1:0]       ln_data,
  output line_st_e                ln_state,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic                    bus_out_valid,
  output logic [1:0]              bus_out_cmd,
  output logic [ADDR_W-1:0]       bus_out_addr,
  output logic [DATA_W-1:0]       bus_out_data,
  input  logic                    fill_valid,
  input  logic [DATA_W-1:0]       fill_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_st_e           st_q;
  logic              rq_we;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wdata;
  logic [ADDR_W-1:0] lk_addr;
  logic              tag_hit, hit, accept, victim_dirty, fill_done;

  assign lk_addr      = (st_q == C_IDLE) ? cpu_req_addr : rq_addr;
  assign a_idx        = lk_addr[IDX_W-1:0];
  assign tag_hit      = (a_state != LN_INV) && (a_tag == lk_addr[ADDR_W-1:IDX_W]);
  assign hit          = cpu_req_we ? (tag_hit && a_state == LN_EXC) : tag_hit;
  assign cpu_req_ready = (st_q == C_IDLE) && !snp_valid;
  assign accept       = cpu_req_valid && cpu_req_ready;
  assign victim_dirty = (a_state == LN_EXC) && (a_tag != rq_addr[ADDR_W-1:IDX_W]);
  assign fill_done    = (st_q == C_WAIT) && fill_valid;

  assign bus_req       = (st_q != C_IDLE);
  assign bus_out_valid = (st_q == C_WB) || (st_q == C_CMD);

  always_comb begin
    bus_out_cmd  = BC_NONE;
    bus_out_addr = rq_addr;
    bus_out_data = '0;
    if (st_q == C_WB) begin
      bus_out_cmd  = BC_WBACK;
      bus_out_addr = {a_tag, rq_addr[IDX_W-1:0]};
      bus_out_data = a_data;
    end else if (st_q == C_CMD) begin
      bus_out_cmd  = rq_we ? BC_WRMISS : BC_RDMISS;
      bus_out_data = rq_we ? rq_wdata : '0;
    end
  end

  always_comb begin
    ln_we    = 1'b0;
    ln_idx   = rq_addr[IDX_W-1:0];
    ln_tag   = rq_addr[ADDR_W-1:IDX_W];
    ln_data  = rq_we ? rq_wdata : fill_data;
    ln_state = rq_we ? LN_EXC : LN_SHR;
    if (accept && cpu_req_we && hit) begin
      ln_we    = 1'b1;
      ln_idx   = cpu_req_addr[IDX_W-1:0];
      ln_tag   = cpu_req_addr[ADDR_W-1:IDX_W];
      ln_data  = cpu_req_wdata;
      ln_state = LN_EXC;
    end else if (fill_done) begin
      ln_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= C_IDLE;
      rq_we         <= 1'b0;
      rq_addr       <= '0;
      rq_wdata      <= '0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      case (st_q)
        C_IDLE: if (accept) begin
          rq_we    <= cpu_req_we;
          rq_addr  <= cpu_req_addr;
          rq_wdata <= cpu_req_wdata;
          if (hit) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= cpu_req_we ? cpu_req_wdata : a_data;
          end else begin
            st_q <= C_ARB;
          end
        end
        C_ARB:  if (bus_gnt) st_q <= victim_dirty ? C_WB : C_CMD;
        C_WB:   st_q <= C_CMD;
        C_CMD:  st_q <= C_WAIT;
        C_WAIT: if (fill_valid) begin
          st_q          <= C_IDLE;
          cpu_rsp_valid <= 1'b1;
          cpu_rsp_rdata <= rq_we ? rq_wdata : fill_data;
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  logic unused_tagw;
  assign unused_tagw = (TAG_W > 0);
endmodule

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_out_valid,
  output logic [1:0]        bus_out_cmd,
  output logic [ADDR_W-1:0] bus_out_addr,
  output logic [DATA_W-1:0] bus_out_data,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_dirty,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx, st_idx, ln_idx;
  line_st_e          a_state, b_state, st_val, ln_state;
  logic [TAG_W-1:0]  a_tag, b_tag, ln_tag;
  logic [DATA_W-1:0] a_data, b_data, ln_data;
  logic              st_we, ln_we;

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
    .st_we(st_we), .st_idx(st_idx), .st_val(st_val),
    .ln_we(ln_we), .ln_idx(ln_idx), .ln_tag(ln_tag), .ln_data(ln_data), .ln_state(ln_state)
  );

  msi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
    .st_we(st_we), .st_idx(st_idx), .st_val(st_val),
    .snp_dirty(snp_dirty), .snp_data(snp_data)
  );

  msi_cpu_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .snp_valid(snp_valid),
    .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .ln_we(ln_we), .ln_idx(ln_idx), .ln_tag(ln_tag), .ln_data(ln_data), .ln_state(ln_state),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_out_valid(bus_out_valid), .bus_out_cmd(bus_out_cmd),
    .bus_out_addr(bus_out_addr), .bus_out_data(bus_out_data),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );
endmodule

// File: rtl/msi_snoop_cache_chk.sv
module msi_snoop_cache_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req_ready,
  input logic       cpu_rsp_valid,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic       bus_out_valid,
  input logic [1:0] bus_out_cmd,
  input logic       fill_valid,
  input logic       snp_valid,
  input logic       snp_dirty
);
  AST_READY_NOT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !bus_req); // R7
  AST_CMD_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> (bus_gnt && bus_req)); // R7
  AST_DIRTY_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_dirty |-> $past(snp_valid)); // R8
  AST_SNOOP_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !bus_req) |=> !cpu_rsp_valid); // R11
  AST_WBACK_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_out_valid && bus_out_cmd == 2'd3) |=> (bus_out_valid && bus_out_cmd != 2'd3)); // R6
  AST_REQ_HELD_TO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(fill_valid)); // R12
endmodule

bind msi_snoop_cache msi_snoop_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_out_valid(bus_out_valid),
  .bus_out_cmd(bus_out_cmd), .fill_valid(fill_valid), .snp_valid(snp_valid),
  .snp_dirty(snp_dirty)
);

// File: tb/msi_snoop_cache_tb.sv
module msi_snoop_cache_tb;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 2;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [DATA_W-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic [DATA_W-1:0] cpu_rsp_rdata;
  logic bus_req, bus_out_valid;
  logic bus_gnt = 1'b0;
  logic [1:0] bus_out_cmd;
  logic [ADDR_W-1:0] bus_out_addr;
  logic [DATA_W-1:0] bus_out_data;
  logic fill_valid = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic snp_dirty;
  logic [DATA_W-1:0] snp_data;

  int n_chk = 0, n_fail = 0;
  logic [DATA_W-1:0] mem [256];

  always #10 clk = ~clk;

  msi_snoop_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_out_valid(bus_out_valid),
    .bus_out_cmd(bus_out_cmd), .bus_out_addr(bus_out_addr), .bus_out_data(bus_out_data),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_dirty(snp_dirty), .snp_data(snp_data)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [15:0] exp_rdata;
    logic [1:0]  exp_cmd;
    logic        exp_wb;
    logic [7:0]  wb_addr;
    logic [15:0] wb_data;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'h04, 16'h0000, 16'hA004, 2'd1, 1'b0, 8'h00, 16'h0000},
    '{1'b0, 8'h04, 16'h0000, 16'hA004, 2'd0, 1'b0, 8'h00, 16'h0000},
    '{1'b1, 8'h04, 16'h1111, 16'h1111, 2'd2, 1'b0, 8'h00, 16'h0000},
    '{1'b0, 8'h04, 16'h0000, 16'h1111, 2'd0, 1'b0, 8'h00, 16'h0000},
    '{1'b1, 8'h04, 16'h2222, 16'h2222, 2'd0, 1'b0, 8'h00, 16'h0000},
    '{1'b0, 8'h08, 16'h0000, 16'hA008, 2'd1, 1'b1, 8'h04, 16'h2222},
    '{1'b0, 8'h04, 16'h0000, 16'h2222, 2'd1, 1'b0, 8'h00, 16'h0000},
    '{1'b1, 8'h05, 16'h3333, 16'h3333, 2'd2, 1'b0, 8'h00, 16'h0000},
    '{1'b1, 8'h09, 16'h4444, 16'h4444, 2'd2, 1'b1, 8'h05, 16'h3333},
    '{1'b0, 8'h05, 16'h0000, 16'h3333, 2'd1, 1'b1, 8'h09, 16'h4444}
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] addr,
                       output logic dirty, output logic [15:0] data);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = addr;
    @(negedge clk);
    snp_valid = 1'b0;
    dirty = snp_dirty; data = snp_data;
    if (dirty) mem[addr] = data;
  endtask

  task automatic cpu_op(input logic we, input logic [7:0] addr, input logic [15:0] wdata,
                        input int gnt_delay, input bit snp_in_delay,
                        input logic [1:0] s_cmd, input logic [7:0] s_addr,
                        output logic [15:0] rdata, output logic [1:0] saw_cmd,
                        output bit saw_wb, output logic [7:0] wb_addr,
                        output logic [15:0] wb_data, output bit saw_req, output bit sd_seen);
    int dly;
    bit fill_arm, done;
    logic [7:0] fill_addr;
    rdata = '0; saw_cmd = 2'd0; saw_wb = 0; wb_addr = '0; wb_data = '0;
    saw_req = 0; sd_seen = 0; fill_arm = 0; done = 0; fill_addr = '0;
    dly = gnt_delay;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = addr; cpu_req_wdata = wdata;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    for (int c = 0; c < 60 && !done; c++) begin
      if (fill_valid) fill_valid = 1'b0;
      if (fill_arm) begin
        fill_valid = 1'b1; fill_data = mem[fill_addr]; fill_arm = 0;
      end
      if (cpu_rsp_valid) begin
        rdata = cpu_rsp_rdata; done = 1;
        if (saw_cmd != 2'd0) chk(bus_req == 1'b0, "R12 bus_req after fill", bus_req, 0);
      end
      if (snp_dirty) begin sd_seen = 1; mem[s_addr] = snp_data; end
      if (snp_valid) snp_valid = 1'b0;
      if (bus_req) saw_req = 1;
      if (bus_out_valid) begin
        if (bus_out_cmd == 2'd3) begin
          saw_wb = 1; wb_addr = bus_out_addr; wb_data = bus_out_data;
          mem[bus_out_addr] = bus_out_data;
        end else begin
          saw_cmd = bus_out_cmd; fill_addr = bus_out_addr; fill_arm = 1;
        end
      end
      if (bus_req && !bus_gnt && !done) begin
        if (dly > 0) begin
          chk(!bus_out_valid && !cpu_req_ready, "R7 idle before grant",
              {bus_out_valid, cpu_req_ready}, 0);
          if (snp_in_delay && dly == gnt_delay) begin
            snp_valid = 1'b1; snp_cmd = s_cmd; snp_addr = s_addr;
          end
          dly--;
        end else begin
          bus_gnt = 1'b1;
        end
      end
      if (!bus_req) bus_gnt = 1'b0;
      if (!done) @(negedge clk);
    end
    bus_gnt = 1'b0;
    if (!done) chk(0, "R2 response timeout", 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd, wbd, sdata;
    logic [1:0] cmd;
    logic [7:0] wba;
    bit wb, rq, sd;
    logic dirty;
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 | 16'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cpu_req_ready == 1'b1, "R1 ready", cpu_req_ready, 1);
    chk(bus_req == 1'b0 && bus_out_valid == 1'b0, "R1 bus idle", {bus_req, bus_out_valid}, 0);
    chk(snp_dirty == 1'b0 && cpu_rsp_valid == 1'b0, "R1 outputs low", {snp_dirty, cpu_rsp_valid}, 0);

    for (int v = 0; v < NVEC; v++) begin
      string tg;
      cpu_op(VEC[v].we, VEC[v].addr, VEC[v].wdata, 0, 0, 2'd0, 8'h00,
             rd, cmd, wb, wba, wbd, rq, sd);
      tg = (VEC[v].exp_cmd == 2'd1) ? "R4" : (VEC[v].exp_cmd == 2'd2) ? "R5" :
           (VEC[v].we ? "R3" : "R2");
      chk(rd == VEC[v].exp_rdata, {tg, " data"}, rd, VEC[v].exp_rdata);
      chk(cmd == VEC[v].exp_cmd, {tg, " bus command"}, cmd, VEC[v].exp_cmd);
      chk(rq == (VEC[v].exp_cmd != 2'd0), {tg, " bus request"}, rq, VEC[v].exp_cmd != 2'd0);
      chk(wb == VEC[v].exp_wb, "R6 write-back presence", wb, VEC[v].exp_wb);
      if (VEC[v].exp_wb)
        chk(wba == VEC[v].wb_addr && wbd == VEC[v].wb_data, "R6 write-back fields",
            {wba, wbd}, {VEC[v].wb_addr, VEC[v].wb_data});
    end

    // R5 write to Shared line with same tag is a full write miss
    cpu_op(1'b1, 8'h04, 16'h5555, 0, 0, 2'd0, 8'h00, rd, cmd, wb, wba, wbd, rq, sd);
    chk(cmd == 2'd2 && !wb, "R5 shared write miss", {cmd, wb}, 3'b100);

    // R11 snoop and CPU request in the same cycle
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h04;
    cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = 8'h04;
    #1;
    chk(cpu_req_ready == 1'b0, "R11 ready low during snoop", cpu_req_ready, 0);
    @(negedge clk);
    snp_valid = 1'b0; cpu_req_valid = 1'b0;
    chk(snp_dirty == 1'b1 && snp_data == 16'h5555, "R8 dirty reply", {snp_dirty, snp_data}, {1'b1, 16'h5555});
    chk(cpu_rsp_valid == 1'b0, "R11 no response", cpu_rsp_valid, 0);
    mem[8'h04] = snp_data;

    // R8 line now Shared: read hits, write misses
    cpu_op(1'b0, 8'h04, 16'h0, 0, 0, 2'd0, 8'h00, rd, cmd, wb, wba, wbd, rq, sd);
    chk(rd == 16'h5555 && !rq, "R8 read hit after downgrade", {rq, rd}, 16'h5555);
    cpu_op(1'b1, 8'h04, 16'h6666, 0, 0, 2'd0, 8'h00, rd, cmd, wb, wba, wbd, rq, sd);
    chk(cmd == 2'd2, "R8 write after downgrade misses", cmd, 2);

    // R9 snooped write miss on Exclusive
    snoop(2'd2, 8'h04, dirty, sdata);
    chk(dirty == 1'b1 && sdata == 16'h6666, "R9 dirty reply", {dirty, sdata}, {1'b1, 16'h6666});
    cpu_op(1'b0, 8'h04, 16'h0, 0, 0, 2'd0, 8'h00, rd, cmd, wb, wba, wbd, rq, sd);
    chk(cmd == 2'd1 && !wb && rd == 16'h6666, "R9 line invalid", {cmd, rd}, {2'd1, 16'h6666});

    // R10 ignored snoops
    snoop(2'd2, 8'h08, dirty, sdata);
    chk(dirty == 1'b0, "R10 other tag no reply", dirty, 0);
    cpu_op(1'b0, 8'h04, 16'h0, 0, 0, 2'd0, 8'h00, rd, cmd, wb, wba, wbd, rq, sd);
    chk(!rq && rd == 16'h6666, "R10 line kept after other tag", {rq, rd}, 16'h6666);
    snoop(2'd3, 8'h04, dirty, sdata);
    chk(dirty == 1'b0, "R10 write-back code no reply", dirty, 0);
    cpu_op(1'b0, 8'h04, 16'h0, 0, 0, 2'd0, 8'h00, rd, cmd, wb, wba, wbd, rq, sd);
    chk(!rq, "R10 line kept after write-back code", rq, 0);

    // R9 snooped write miss on Shared
    snoop(2'd2, 8'h04, dirty, sdata);
    chk(dirty == 1'b0, "R9 shared no dirty reply", dirty, 0);
    cpu_op(1'b0, 8'h04, 16'h0, 0, 0, 2'd0, 8'h00, rd, cmd, wb, wba, wbd, rq, sd);
    chk(cmd == 2'd1, "R9 shared line invalidated", cmd, 1);

    // R7 victim invalidated by a snoop while waiting for grant
    cpu_op(1'b1, 8'h06, 16'h7777, 0, 0, 2'd0, 8'h00, rd, cmd, wb, wba, wbd, rq, sd);
    chk(cmd == 2'd2 && !wb, "R5 write miss to invalid line", {cmd, wb}, 3'b100);
    cpu_op(1'b0, 8'h0A, 16'h0, 4, 1, 2'd2, 8'h06, rd, cmd, wb, wba, wbd, rq, sd);
    chk(sd == 1'b1, "R9 dirty reply while waiting", sd, 1);
    chk(!wb && cmd == 2'd1, "R7 no write-back of snooped victim", {wb, cmd}, 3'b001);
    chk(rd == 16'hA00A, "R4 fill data", rd, 16'hA00A);

    // R7 delayed grant with a dirty victim
    cpu_op(1'b1, 8'h0E, 16'h8888, 0, 0, 2'd0, 8'h00, rd, cmd, wb, wba, wbd, rq, sd);
    cpu_op(1'b0, 8'h06, 16'h0, 3, 0, 2'd0, 8'h00, rd, cmd, wb, wba, wbd, rq, sd);
    chk(wb && wba == 8'h0E && wbd == 16'h8888, "R6 write-back after delayed grant",
        {wb, wba, wbd}, {1'b1, 8'h0E, 16'h8888});
    chk(rd == 16'h7777, "R4 fill returns snooped data", rd, 16'h7777);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule